// File: doc/BRIEF.md
# Multi-Channel DMA Service Engine

This engine decides, on every clock, which of its DMA channels owns the memory port and then walks that channel through its transfer one unit at a time. Each channel carries a request flag, a mask bit from the programming side, a 16-bit count value, a 16-bit start address, two page bytes, a direction bit and an auto-reload bit. A channel is eligible when it is unmasked, its request flag is set and its transfer is not yet complete. The lowest-numbered eligible channel wins the port. Its acknowledge line goes high and the 31-bit physical address of the current unit is presented.

A device-ready input paces the transfer. Each cycle in which the port is offered and ready is high moves the winning channel's progress counter forward by one unit. The request flag is a single bit shared by two sources. Software set and clear pulses drive it, and so do the rising and falling edges of the hardware request line. When progress reaches the programmed length, the terminal-count flag of that channel is raised. The channel then either parks until its progress is reloaded or wraps to zero and carries on.

Top module: `dma_svc_top`

## Requirements
- R1: A channel is granted only while its mask bit is 0 (1 means masked), its request flag is 1 and its progress is below its length.
- R2: Among eligible channels, channel 0 has the highest priority and the highest channel number the lowest. `dack` is one-hot on the winner, or zero when no channel is eligible. `memValid` is 1 exactly when some channel is eligible.
- R3: A request flag becomes 1 after an edge that sees a rising `dreq` or a `chReqSet` pulse. It becomes 0 after an edge that sees a falling `dreq` or a `chReqClr` pulse. When both happen on the same edge, set wins.
- R4: `memAddr` = {`pageHi`[6:0], `pageLo`, `curAddr`} of the winner plus its progress, or minus its progress when its `chDec` bit is 1. The result is taken modulo 2^31. Bit 7 of the high page is ignored.
- R5: The winner's progress rises by one on each edge where `memValid` and `memReady` are both 1. All other progress values hold.
- R6: The length is (`baseCount` + 1) << WORD_SHIFT. On the edge that takes the unit making progress equal to the length, the channel's `tcStatus` bit becomes 1.
- R7: With `chAuto` at 0, a channel that reaches its length keeps progress at the length and is not granted again until it is reloaded.
- R8: With `chAuto` at 1, progress returns to 0 on terminal count and servicing continues while the request stays set.
- R9: A `progLoad` pulse zeroes that channel's progress and clears its `tcStatus` bit. It takes priority over an advance on the same edge.
- R10: `memCh` reports the winning channel number, offset by NCH when WORD_SHIFT is nonzero.
- R11: Synchronous active-high `rst` clears all request flags, terminal-count flags and progress, and leaves `dack` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chMask | input | NCH | Per-channel mask, 1 blocks service |
| chReqSet | input | NCH | Software request set pulse |
| chReqClr | input | NCH | Software request clear pulse |
| dreq | input | NCH | Hardware request level per channel |
| chDec | input | NCH | 1 selects downward addressing |
| chAuto | input | NCH | 1 selects wrap-around on terminal count |
| progLoad | input | NCH | Reload pulse, zeroes progress |
| baseCount | input | NCH x 16 | Programmed count (length minus one) |
| curAddr | input | NCH x 16 | Start address within the page |
| pageLo | input | NCH x 8 | Page byte, address bits 23:16 |
| pageHi | input | NCH x 8 | High page byte, bits 6:0 form address bits 30:24 |
| memReady | input | 1 | Device ready, accepts the offered unit |
| memValid | output | 1 | A channel is offering a unit |
| memAddr | output | 31 | Physical address of the offered unit |
| memCh | output | CHW+1 | Channel number reported to the device |
| dack | output | NCH | Per-channel acknowledge |
| reqStatus | output | NCH | Request flags |
| tcStatus | output | NCH | Terminal-count flags |

## Verification
The inline assertions check several rules on every cycle. They check that the grant is one-hot and goes only to an unmasked, requesting channel. They check that a rising request line always lands in the flag, and that progress either steps by exactly one, holds or reloads to zero. They check that the terminal-count flag appears after a final unit and that reset empties the state. Some behaviour can only be shown by the bench's scenarios, which compare against a behavioural model every cycle. That includes the lowest-number priority between competing channels and address arithmetic across page boundaries in both directions. It also includes parking versus wrap-around at terminal count, the set-wins collision on the request flag and recovery after a reload.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;
  localparam int CH_IDX_MAX_W = 3;

  // strobes from control to datapath, one bundle per cycle
  typedef struct packed {
    logic                    adv;   // winner takes one unit this edge
    logic                    wrap;  // winner wraps to zero on its last unit
    logic [CH_IDX_MAX_W-1:0] ch;    // winner index
  } svc_strobe_t;
endpackage

// File: rtl/dma_svc_ctrl.sv
module dma_svc_ctrl
  import dma_svc_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chMask,
  input  logic [NCH-1:0] chReqSet,
  input  logic [NCH-1:0] chReqClr,
  input  logic [NCH-1:0] dreq,
  input  logic [NCH-1:0] chAuto,
  input  logic [NCH-1:0] progLoad,
  input  logic [NCH-1:0] doneVec,
  input  logic [NCH-1:0] lastVec,
  input  logic           memReady,
  output svc_strobe_t    strb,
  output logic           memValid,
  output logic [NCH-1:0] dack,
  output logic [NCH-1:0] reqStatus,
  output logic [NCH-1:0] tcStatus
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] dreqPrev, reqQ, tcQ, eligible, setReq, clrReq;
  logic [CHW-1:0] sel;
  logic           found;

  assign eligible = ~chMask & reqQ & ~doneVec;
  assign setReq   = (dreq & ~dreqPrev) | chReqSet;
  assign clrReq   = (~dreq & dreqPrev) | chReqClr;

  // fixed priority, lowest index first
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (eligible[i] && !found) begin
        found = 1'b1;
        sel   = CHW'(i);
      end
    end
  end

  assign memValid = found;

  always_comb begin
    strb.adv  = found & memReady;
    strb.wrap = chAuto[sel];
    strb.ch   = CH_IDX_MAX_W'(sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dreqPrev <= '0;
      reqQ     <= '0;
      tcQ      <= '0;
    end else begin
      dreqPrev <= dreq;
      for (int i = 0; i < NCH; i++) begin
        if (setReq[i])      reqQ[i] <= 1'b1;
        else if (clrReq[i]) reqQ[i] <= 1'b0;
        if (progLoad[i])
          tcQ[i] <= 1'b0;
        else if (strb.adv && (sel == CHW'(i)) && lastVec[i])
          tcQ[i] <= 1'b1;
      end
    end
  end

  assign reqStatus = reqQ;
  assign tcStatus  = tcQ;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(dack)); // R2

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign dack[g] = found && (sel == CHW'(g));

    AST_GRANT_OK: assert property (@(posedge clk) disable iff (rst)
      dack[g] |-> (!chMask[g] && reqStatus[g])); // R1
    AST_DREQ_SET: assert property (@(posedge clk) disable iff (rst)
      $rose(dreq[g]) |=> reqStatus[g]); // R3
    AST_TC_MARK: assert property (@(posedge clk) disable iff (rst)
      (strb.adv && strb.ch == CH_IDX_MAX_W'(g) && lastVec[g] && !progLoad[g]) |=> tcStatus[g]); // R6
  end
endmodule

// File: rtl/dma_svc_dp.sv
module dma_svc_dp
  import dma_svc_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int WORD_SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  svc_strobe_t          strb,
  input  logic [NCH-1:0]       progLoad,
  input  logic [NCH-1:0]       chDec,
  input  logic [NCH-1:0][15:0] baseCount,
  input  logic [NCH-1:0][15:0] curAddr,
  input  logic [NCH-1:0][7:0]  pageLo,
  input  logic [NCH-1:0][7:0]  pageHi,
  output logic [30:0]          memAddr,
  output logic [NCH-1:0]       doneVec,
  output logic [NCH-1:0]       lastVec
);
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PW  = 17 + WORD_SHIFT;
  localparam int AW  = 31;

  logic [PW-1:0]  progress [NCH];
  logic [PW-1:0]  lenV     [NCH];
  logic [CHW-1:0] sel;
  logic [AW-1:0]  physBase, offset;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit        = strb.adv && (strb.ch == CH_IDX_MAX_W'(g));
    assign lenV[g]    = (PW'(baseCount[g]) + PW'(1)) << WORD_SHIFT;
    assign lastVec[g] = (progress[g] + PW'(1)) == lenV[g];
    assign doneVec[g] = progress[g] == lenV[g];

    always_ff @(posedge clk) begin
      if (rst || progLoad[g])
        progress[g] <= '0;
      else if (hit)
        progress[g] <= lastVec[g] ? (strb.wrap ? '0 : lenV[g]) : progress[g] + PW'(1);
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
      (hit && !lastVec[g] && !progLoad[g]) |=> progress[g] == $past(progress[g]) + PW'(1)); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!hit && !progLoad[g]) |=> $stable(progress[g])); // R5
    AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
      progLoad[g] |=> progress[g] == '0); // R9
  end

  assign sel      = strb.ch[CHW-1:0];
  assign physBase = {pageHi[sel][6:0], pageLo[sel], curAddr[sel]};
  assign offset   = AW'(progress[sel]);
  assign memAddr  = chDec[sel] ? physBase - offset : physBase + offset;
endmodule

// File: rtl/dma_svc_top.sv
module dma_svc_top
  import dma_svc_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int WORD_SHIFT = 0,
  localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       chMask,
  input  logic [NCH-1:0]       chReqSet,
  input  logic [NCH-1:0]       chReqClr,
  input  logic [NCH-1:0]       dreq,
  input  logic [NCH-1:0]       chDec,
  input  logic [NCH-1:0]       chAuto,
  input  logic [NCH-1:0]       progLoad,
  input  logic [NCH-1:0][15:0] baseCount,
  input  logic [NCH-1:0][15:0] curAddr,
  input  logic [NCH-1:0][7:0]  pageLo,
  input  logic [NCH-1:0][7:0]  pageHi,
  input  logic                 memReady,
  output logic                 memValid,
  output logic [30:0]          memAddr,
  output logic [CHW:0]         memCh,
  output logic [NCH-1:0]       dack,
  output logic [NCH-1:0]       reqStatus,
  output logic [NCH-1:0]       tcStatus
);
  svc_strobe_t    strb;
  logic [NCH-1:0] doneVec, lastVec;

  dma_svc_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst(rst), .chMask(chMask), .chReqSet(chReqSet), .chReqClr(chReqClr),
    .dreq(dreq), .chAuto(chAuto), .progLoad(progLoad), .doneVec(doneVec),
    .lastVec(lastVec), .memReady(memReady), .strb(strb), .memValid(memValid),
    .dack(dack), .reqStatus(reqStatus), .tcStatus(tcStatus)
  );

  dma_svc_dp #(.NCH(NCH), .WORD_SHIFT(WORD_SHIFT)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .progLoad(progLoad), .chDec(chDec),
    .baseCount(baseCount), .curAddr(curAddr), .pageLo(pageLo), .pageHi(pageHi),
    .memAddr(memAddr), .doneVec(doneVec), .lastVec(lastVec)
  );

  // word-shift controllers report the channel offset by NCH
  assign memCh = {1'(WORD_SHIFT != 0), strb.ch[CHW-1:0]};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (dack == '0 && reqStatus == '0 && tcStatus == '0)); // R11
endmodule

// File: tb/dma_svc_top_tb.sv
module dma_svc_top_tb;
  localparam int NCH = 4;
  localparam int WS  = 0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic [3:0] chMask, chReqSet, chReqClr, dreq, chDec, chAuto, progLoad;
  logic [3:0][15:0] baseCount, curAddr;
  logic [3:0][7:0] pageLo, pageHi;
  logic memReady, memValid;
  logic [30:0] memAddr;
  logic [2:0] memCh;
  logic [3:0] dack, reqStatus, tcStatus;

  dma_svc_top #(.NCH(NCH), .WORD_SHIFT(WS)) u_dut (
    .clk(clk), .rst(rst), .chMask(chMask), .chReqSet(chReqSet), .chReqClr(chReqClr),
    .dreq(dreq), .chDec(chDec), .chAuto(chAuto), .progLoad(progLoad),
    .baseCount(baseCount), .curAddr(curAddr), .pageLo(pageLo), .pageHi(pageHi),
    .memReady(memReady), .memValid(memValid), .memAddr(memAddr), .memCh(memCh),
    .dack(dack), .reqStatus(reqStatus), .tcStatus(tcStatus)
  );

  int total = 0;
  int bad   = 0;
  int mReq[4], mTc[4], mProg[4], mPrev[4];

  function automatic int lenOf(int i);
    return (int'(baseCount[i]) + 1) << WS;
  endfunction

  function automatic int selOf();
    for (int i = 0; i < NCH; i++)
      if (!chMask[i] && mReq[i] != 0 && mProg[i] != lenOf(i)) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, advanced once per rising edge
  task automatic modelEdge();
    int s;
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin mReq[i] = 0; mTc[i] = 0; mProg[i] = 0; mPrev[i] = 0; end
    end else begin
      s = selOf();
      if (s >= 0 && memReady) begin
        if (mProg[s] + 1 == lenOf(s)) begin
          mTc[s] = 1;
          mProg[s] = chAuto[s] ? 0 : lenOf(s);
        end else mProg[s]++;
      end
      for (int i = 0; i < NCH; i++) begin
        if (progLoad[i]) begin mProg[i] = 0; mTc[i] = 0; end
        if ((dreq[i] && mPrev[i] == 0) || chReqSet[i]) mReq[i] = 1;
        else if ((!dreq[i] && mPrev[i] != 0) || chReqClr[i]) mReq[i] = 0;
        mPrev[i] = int'(dreq[i]);
      end
    end
  endtask

  task automatic compareAll();
    int s;
    longint b, a;
    logic [3:0] expDack, expReq, expTc;
    s = selOf();
    expDack = (s >= 0) ? 4'(1 << s) : 4'h0;
    for (int i = 0; i < NCH; i++) begin
      expReq[i] = mReq[i] != 0;
      expTc[i]  = mTc[i] != 0;
    end
    check(memValid == (s >= 0), "R2 memValid", longint'(memValid), longint'(s >= 0));
    check(dack == expDack, "R2 dack", longint'(dack), longint'(expDack));
    check(reqStatus == expReq, "R3 reqStatus", longint'(reqStatus), longint'(expReq));
    check(tcStatus == expTc, "R6 tcStatus", longint'(tcStatus), longint'(expTc));
    if (s >= 0) begin
      b = (longint'(pageHi[s] & 8'h7F) << 24) | (longint'(pageLo[s]) << 16) | longint'(curAddr[s]);
      a = chDec[s] ? b - longint'(mProg[s]) : b + longint'(mProg[s]);
      a = a & 64'h7FFF_FFFF;
      check(memAddr == 31'(a), "R4 R5 memAddr", longint'(memAddr), a);
      check(memCh == 3'(s + 4 * WS), "R10 memCh", longint'(memCh), longint'(s + 4 * WS));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    summary();
  end

  initial begin
    rst = 1'b1; chMask = 4'hF; chReqSet = '0; chReqClr = '0; dreq = '0; chDec = '0;
    chAuto = '0; progLoad = '0; baseCount = '0; curAddr = '0; pageLo = '0; pageHi = '0;
    memReady = 1'b0;
    repeat (3) tick();
    // R11: reset state
    check(dack == 0 && tcStatus == 0 && reqStatus == 0 && !memValid, "R11 reset",
          longint'({memValid, dack, reqStatus, tcStatus}), 0);
    rst = 1'b0;
    tick();

    // channel 1, length 4, upward, high page bit 7 must be dropped
    baseCount[1] = 16'd3; curAddr[1] = 16'h1000; pageLo[1] = 8'h12; pageHi[1] = 8'hFF;
    progLoad[1] = 1'b1; tick(); progLoad[1] = 1'b0;
    chReqSet[1] = 1'b1; tick(); chReqSet[1] = 1'b0;
    tick();
    check(!memValid && reqStatus[1], "R1 masked", longint'(memValid), 0);
    chMask = 4'b1101;
    tick();
    check(memAddr == 31'h7F12_1000, "R4 page", longint'(memAddr), 64'h7F12_1000);
    memReady = 1'b1;
    repeat (6) tick();
    check(tcStatus[1] == 1'b1, "R6 tc", longint'(tcStatus), 2);
    check(!memValid && reqStatus[1], "R7 parked", longint'(memValid), 0);

    // R9: reload resumes the channel
    progLoad[1] = 1'b1; tick(); progLoad[1] = 1'b0;
    check(tcStatus[1] == 1'b0, "R9 reload", longint'(tcStatus), 0);
    tick();
    check(memValid && dack == 4'b0010, "R9 resume", longint'(dack), 2);

    // R2: competing channels, downward ch2 crossing a page, paced ready
    baseCount[2] = 16'd5; curAddr[2] = 16'h0003; pageLo[2] = 8'h40; chDec[2] = 1'b1;
    baseCount[0] = 16'd1; curAddr[0] = 16'h0200; pageLo[0] = 8'h01;
    progLoad[2] = 1'b1; progLoad[0] = 1'b1; tick(); progLoad = '0;
    chMask = 4'h0; dreq[0] = 1'b1; dreq[2] = 1'b1; memReady = 1'b0;
    tick();
    tick();
    check(dack == 4'b0001, "R2 priority", longint'(dack), 1);
    for (int k = 0; k < 24; k++) begin
      memReady = (k % 3) != 0;
      tick();
    end
    check(tcStatus[2] && !memValid, "R7 ch2 done", longint'(tcStatus), 4);

    // R3: set wins over clear, then clear alone
    chReqSet[3] = 1'b1; chReqClr[3] = 1'b1; chMask = 4'hF; tick();
    chReqSet[3] = 1'b0; chReqClr[3] = 1'b0;
    check(reqStatus[3] == 1'b1, "R3 set wins", longint'(reqStatus), 8);
    chReqClr[3] = 1'b1; tick(); chReqClr[3] = 1'b0;
    check(reqStatus[3] == 1'b0, "R3 clear", longint'(reqStatus), 0);

    // R8: auto wrap on channel 3
    baseCount[3] = 16'd1; curAddr[3] = 16'hFFFF; pageLo[3] = 8'hAB; pageHi[3] = 8'h05; chAuto[3] = 1'b1;
    progLoad[3] = 1'b1; tick(); progLoad[3] = 1'b0;
    chMask = 4'b0111; dreq[3] = 1'b1; memReady = 1'b1;
    repeat (7) tick();
    check(tcStatus[3] && memValid && dack == 4'b1000, "R8 wrap", longint'(dack), 8);
    dreq[3] = 1'b0; tick();
    check(reqStatus[3] == 1'b0 && !memValid, "R3 dreq fall", longint'(reqStatus), 0);

    // R11: reset during activity
    chMask = 4'h0; dreq = 4'hF; tick(); tick();
    rst = 1'b1; tick();
    check(dack == 0 && tcStatus == 0 && reqStatus == 0 && !memValid, "R11 mid-run",
          longint'({memValid, dack, reqStatus, tcStatus}), 0);
    rst = 1'b0; dreq = '0; tick(); tick();
    summary();
  end
endmodule